// File: doc/BRIEF.md
# Supply Fault Protection Sequencer

This block supervises the supply rail of an off-line flyback controller and decides, cycle by cycle, whether the power switch may be driven. It receives already-synchronised comparator flags for the rail: above the turn-on level, below the turn-off level, over-voltage, feedback overload, and pin faults. A strobe that pulses once per switching period times the overload delay. The block returns a gate-allow signal for the driver, an enable for the high-voltage startup source, and a 3-bit status code.

Startup and shutdown follow an undervoltage lockout with hysteresis. While the rail sits between the two thresholds, the current mode is kept. A sustained overload is counted in switching periods and then latches the gate off. The latch is released only on the second fall of the rail below the turn-off level, so the supply hiccups slowly. Over-voltage and pin faults remove the gate at once through a combinational mask. Over-voltage then holds the gate off until the rail has collapsed and restarted. A pin fault releases as soon as the fault flag clears.

Top module: `supply_guard_seq`

## Requirements
- R1: In reset and after it, the status is 0 (off) and the gate is disallowed. The startup source is enabled whenever the turn-on flag is low.
- R2: Status codes are 0 off, 1 run, 2 overload latched, 3 over-voltage, 4 pin fault. From off, the cycle after the turn-on flag is high with the turn-off flag low, the status is 1 and the gate is allowed.
- R3: In run, the block stays in run while neither threshold flag is set (hysteresis band). The cycle after the turn-off flag is seen, it returns to off.
- R4: The startup source is disabled in run, pin fault and over-voltage. In off it is enabled exactly while the turn-on flag is low.
- R5: In run, the block enters overload latched on the OVL_CYCLES-th strobe that arrives while the overload flag has been high without a break. Cycles without a strobe hold the count.
- R6: Any cycle with the overload flag low clears the overload count. After that, a full OVL_CYCLES strobes are needed again.
- R7: Overload latched keeps the gate off and ignores over-voltage and pin-fault flags. It returns to off on the REL_EVENTS-th rising edge of the turn-off flag (default 2).
- R8: In overload latched, the startup source is enabled from the first such rising edge until the turn-on flag is seen.
- R9: The over-voltage flag drops the gate-allow output in the same cycle. Run moves to status 3, which holds until the turn-off flag is seen, then goes to off.
- R10: The pin-fault flag drops the gate-allow output in the same cycle. Run moves to status 4, which returns to run when the flag clears, or to off if the turn-off flag is seen.
- R11: In run, priority is pin fault, then over-voltage, then turn-off flag, then overload expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_above_on | input | 1 | Rail is above the turn-on threshold |
| vcc_below_off | input | 1 | Rail is below the turn-off threshold |
| vcc_ovp | input | 1 | Rail over-voltage flag |
| fb_overload | input | 1 | Feedback above the overload level |
| pin_fault | input | 1 | Timing-pin short/open or sense-pin open |
| sw_strobe | input | 1 | One pulse per switching period |
| gate_allow | output | 1 | Driver may switch |
| start_src_en | output | 1 | Enable for the high-voltage startup source |
| status | output | 3 | Current state code (see R2) |

## Verification
The bench builds the block with OVL_CYCLES set to 20 instead of 1950 and keeps REL_EVENTS at 2. This makes the full overload delay, its break-and-restart case and the two-event release short enough to reach many times in random traffic. With the default delay, that traffic would almost never hold the overload flag long enough to trip. The bench then drives weighted random flags against a cycle model and replays directed sequences for the exact strobe boundary, the simultaneous-fault priority order and the same-cycle gate masking.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

    typedef enum logic [2:0] {
        GS_OFF  = 3'd0,
        GS_RUN  = 3'd1,
        GS_OLP  = 3'd2,
        GS_OVP  = 3'd3,
        GS_PINF = 3'd4
    } guard_state_e;

endpackage

// File: rtl/ovl_delay_timer.sv
module ovl_delay_timer #(
    parameter int CYCLES = 1950
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic strobe,
    input  logic overload,
    output logic expired
);
    localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expired = enable && overload && strobe && (cnt_q == LAST);
        cnt_d   = cnt_q;
        if (!enable || !overload) begin
            cnt_d = '0;
        end else if (strobe) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uv_release_counter.sv
module uv_release_counter #(
    parameter int EVENTS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic below_off,
    input  logic above_on,
    output logic release_now,
    output logic armed
);
    localparam int EW = (EVENTS > 2) ? $clog2(EVENTS) : 1;
    localparam logic [EW-1:0] LAST = EW'(EVENTS - 1);

    typedef struct packed {
        logic [EW-1:0] cnt;
        logic          armed;
        logic          prev;
    } rel_regs_t;

    rel_regs_t r_d, r_q;
    logic      uv_event;

    always_comb begin
        uv_event    = below_off && !r_q.prev;
        release_now = active && uv_event && (r_q.cnt == LAST);
        r_d         = r_q;
        r_d.prev    = below_off;
        if (!active) begin
            r_d.cnt   = '0;
            r_d.armed = 1'b0;
        end else begin
            if (uv_event) begin
                r_d.cnt   = (r_q.cnt == LAST) ? '0 : r_q.cnt + 1'b1;
                r_d.armed = 1'b1;
            end else if (above_on) begin
                r_d.armed = 1'b0;
            end
        end
    end

    assign armed = r_q.armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/supply_guard_seq.sv
module supply_guard_seq
    import supply_guard_pkg::*;
#(
    parameter int OVL_CYCLES = 1950,
    parameter int REL_EVENTS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vcc_above_on,
    input  logic       vcc_below_off,
    input  logic       vcc_ovp,
    input  logic       fb_overload,
    input  logic       pin_fault,
    input  logic       sw_strobe,
    output logic       gate_allow,
    output logic       start_src_en,
    output logic [2:0] status
);
    typedef struct packed {
        guard_state_e st;
    } seq_regs_t;

    seq_regs_t s_d, s_q;
    logic      ovl_expired;
    logic      rel_now;
    logic      rel_armed;

    ovl_delay_timer #(.CYCLES(OVL_CYCLES)) u_ovl (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (s_q.st == GS_RUN),
        .strobe   (sw_strobe),
        .overload (fb_overload),
        .expired  (ovl_expired)
    );

    uv_release_counter #(.EVENTS(REL_EVENTS)) u_rel (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (s_q.st == GS_OLP),
        .below_off   (vcc_below_off),
        .above_on    (vcc_above_on),
        .release_now (rel_now),
        .armed       (rel_armed)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            GS_OFF: begin
                if (vcc_above_on && !vcc_below_off) s_d.st = GS_RUN;
            end
            GS_RUN: begin
                if (pin_fault)          s_d.st = GS_PINF;
                else if (vcc_ovp)       s_d.st = GS_OVP;
                else if (vcc_below_off) s_d.st = GS_OFF;
                else if (ovl_expired)   s_d.st = GS_OLP;
            end
            GS_PINF: begin
                if (vcc_below_off)   s_d.st = GS_OFF;
                else if (!pin_fault) s_d.st = GS_RUN;
            end
            GS_OVP: begin
                if (vcc_below_off) s_d.st = GS_OFF;
            end
            GS_OLP: begin
                if (rel_now) s_d.st = GS_OFF;
            end
            default: s_d.st = GS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.st <= GS_OFF;
        else        s_q    <= s_d;
    end

    assign gate_allow   = (s_q.st == GS_RUN) && !pin_fault && !vcc_ovp;
    assign start_src_en = ((s_q.st == GS_OFF) && !vcc_above_on) ||
                          ((s_q.st == GS_OLP) && rel_armed);
    assign status       = s_q.st;
endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vcc_above_on,
    input logic       vcc_below_off,
    input logic       vcc_ovp,
    input logic       pin_fault,
    input logic       gate_allow,
    input logic       start_src_en,
    input logic [2:0] status
);
    a_r2_start_run: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd0 && vcc_above_on && !vcc_below_off) |=> status == 3'd1);

    a_r3_uv_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd1 && vcc_below_off && !pin_fault && !vcc_ovp) |=> status == 3'd0);

    a_r4_src_off_run: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd1) |-> !start_src_en);

    a_r7_olp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd2 && !vcc_below_off) |=> status == 3'd2);

    a_r9_ovp_gate: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_ovp |-> !gate_allow);

    a_r10_pin_gate: assert property (@(posedge clk) disable iff (!rst_n)
        pin_fault |-> !gate_allow);

    a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        status <= 3'd4);
endmodule

bind supply_guard_seq supply_guard_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .vcc_above_on  (vcc_above_on),
    .vcc_below_off (vcc_below_off),
    .vcc_ovp       (vcc_ovp),
    .pin_fault     (pin_fault),
    .gate_allow    (gate_allow),
    .start_src_en  (start_src_en),
    .status        (status)
);

// File: tb/tb_supply_guard_seq.sv
module tb_supply_guard_seq;
    localparam int N = 20;
    localparam int E = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic i_on = 1'b0, i_off = 1'b1, i_ovp = 1'b0, i_olf = 1'b0, i_pin = 1'b0, i_stb = 1'b0;
    logic gate_allow, start_src_en;
    logic [2:0] status;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int m_state = 0, m_cnt = 0, m_uvc = 0, m_armed = 0, m_prev = 0;

    always #2 clk = ~clk;

    supply_guard_seq #(.OVL_CYCLES(N), .REL_EVENTS(E)) dut (
        .clk(clk), .rst_n(rst_n),
        .vcc_above_on(i_on), .vcc_below_off(i_off), .vcc_ovp(i_ovp),
        .fb_overload(i_olf), .pin_fault(i_pin), .sw_strobe(i_stb),
        .gate_allow(gate_allow), .start_src_en(start_src_en), .status(status)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_gate();
        return (m_state == 1 && !i_pin && !i_ovp) ? 1 : 0;
    endfunction

    function automatic int exp_src();
        return ((m_state == 0 && !i_on) || (m_state == 2 && m_armed != 0)) ? 1 : 0;
    endfunction

    task automatic mdl_step();
        int ns = m_state;
        int ev = (i_off && m_prev == 0) ? 1 : 0;
        case (m_state)
            0: if (i_on && !i_off) ns = 1;
            1: if (i_pin) ns = 4; else if (i_ovp) ns = 3; else if (i_off) ns = 0;
               else if (i_stb && i_olf && m_cnt == N-1) ns = 2;
            4: if (i_off) ns = 0; else if (!i_pin) ns = 1;
            3: if (i_off) ns = 0;
            2: if (ev != 0 && m_uvc == E-1) ns = 0;
            default: ns = 0;
        endcase
        if (m_state != 1 || !i_olf) m_cnt = 0;
        else if (i_stb) m_cnt = (m_cnt == N-1) ? 0 : m_cnt + 1;
        if (m_state != 2) begin m_uvc = 0; m_armed = 0; end
        else if (ev != 0) begin m_uvc = (m_uvc == E-1) ? 0 : m_uvc + 1; m_armed = 1; end
        else if (i_on) m_armed = 0;
        m_prev = i_off ? 1 : 0;
        m_state = ns;
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " status"}, int'(status), m_state);
        chk({tag, " gate"}, int'(gate_allow), exp_gate());
        chk({tag, " src"}, int'(start_src_en), exp_src());
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        mdl_step();
        #1;
        compare_all(tag);
    endtask

    task automatic setf(input logic on, input logic off, input logic ovp,
                        input logic olf, input logic pin, input logic stb);
        i_on = on; i_off = off; i_ovp = ovp; i_olf = olf; i_pin = pin; i_stb = stb;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = int'($urandom(32'h5eed_0017));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 status", int'(status), 0);
        chk("R1 gate", int'(gate_allow), 0);
        chk("R1 src", int'(start_src_en), 1);
        rst_n = 1'b1;
        m_prev = 1;
        tick("R1");
        // hysteresis band from off
        setf(0, 0, 0, 0, 0, 0); tick("R4");
        chk("R4 src band", int'(start_src_en), 1);
        setf(1, 0, 0, 0, 0, 0); tick("R2");
        chk("R2 run", int'(status), 1);
        chk("R4 src run", int'(start_src_en), 0);
        setf(0, 0, 0, 0, 0, 0); tick("R3"); tick("R3");
        chk("R3 band holds run", int'(status), 1);
        setf(0, 1, 0, 0, 0, 0); tick("R3");
        chk("R3 stop", int'(status), 0);
        setf(1, 0, 0, 0, 0, 0); tick("R2");
        // R5: exact count, strobe gaps hold
        setf(1, 0, 0, 1, 0, 1);
        for (int k = 0; k < N-1; k++) begin
            tick("R5");
            i_stb = 1'b0; tick("R5"); i_stb = 1'b1;
        end
        chk("R5 before last", int'(status), 1);
        // R6: a break clears the count
        i_olf = 1'b0; tick("R6"); i_olf = 1'b1;
        for (int k = 0; k < N-1; k++) tick("R6");
        chk("R6 restart count", int'(status), 1);
        tick("R5");
        chk("R5 latched", int'(status), 2);
        // R7: faults ignored while latched
        setf(0, 0, 1, 0, 1, 0); tick("R7"); tick("R7");
        chk("R7 hold", int'(status), 2);
        setf(0, 1, 0, 0, 0, 0); tick("R8");
        chk("R8 armed src", int'(start_src_en), 1);
        chk("R7 first event", int'(status), 2);
        setf(0, 0, 0, 0, 0, 0); tick("R8");
        setf(1, 0, 0, 0, 0, 0); tick("R8");
        chk("R8 disarm", int'(start_src_en), 0);
        setf(0, 0, 0, 0, 0, 0); tick("R7");
        setf(0, 1, 0, 0, 0, 0); tick("R7");
        chk("R7 release", int'(status), 0);
        setf(1, 0, 0, 0, 0, 0); tick("R2");
        // R9: over-voltage hiccup
        i_ovp = 1'b1; #1;
        chk("R9 gate same cycle", int'(gate_allow), 0);
        tick("R9");
        chk("R9 ovp code", int'(status), 3);
        setf(1, 0, 0, 0, 0, 0); tick("R9");
        chk("R9 hold", int'(status), 3);
        setf(0, 1, 0, 0, 0, 0); tick("R9");
        chk("R9 to off", int'(status), 0);
        setf(1, 0, 0, 0, 0, 0); tick("R2");
        // R10: pin fault
        i_pin = 1'b1; #1;
        chk("R10 gate same cycle", int'(gate_allow), 0);
        tick("R10");
        chk("R10 code", int'(status), 4);
        i_pin = 1'b0; tick("R10");
        chk("R10 back", int'(status), 1);
        // R11: priority
        setf(0, 1, 1, 1, 1, 1); tick("R11");
        chk("R11 pin first", int'(status), 4);
        setf(0, 1, 1, 0, 0, 0); tick("R11");
        chk("R11 off", int'(status), 0);
        setf(1, 0, 1, 0, 0, 0); tick("R11"); tick("R11");
        chk("R11 ovp over uv", int'(status), 3);
        // random mix
        for (int k = 0; k < 6000; k++) begin
            int lv = int'($urandom_range(0, 9));
            i_on  = (lv >= 7);
            i_off = (lv == 0);
            i_ovp = ($urandom_range(0, 40) == 0);
            i_pin = ($urandom_range(0, 30) == 0);
            i_olf = ($urandom_range(0, 50) != 0);
            i_stb = ($urandom_range(0, 1) == 1);
            tick("R11");
        end
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule